// File: doc/BRIEF.md
# Nibble-Loaded 8-Bit Auto-Reload Timer

An 8-bit up-counter that a 4-bit processor programs and reads through three 4-bit registers: a control register and two nibble registers that serve both as load value and as count status. The counter advances on ticks from one of four prescaler taps, picked by a 2-bit select field. When the count passes from FE to FF hex, the block pulses an event flag toward the interrupt controller.

The value in the high nibble register reaches the counter only together with a write to the low nibble. That low-nibble write loads all eight bits at once. The auto-reload request in the control register takes effect only at such a load. When reload is active, a count of FF is replaced by the stored load value on the next 8 kHz tick. Loading FF stops the timer. Reading the low nibble returns the live low half of the count and captures the high half, so that a following read of the high nibble returns a consistent value.

Top module: `nib_timer`

## Requirements
- R1: After reset the control register reads 0 (timer disabled, auto-reload off, select 0), the count is 00 and `evt_o` is low.
- R2: Register map on `addr_i`: 0 = control, 1 = low nibble, 2 = high nibble, 3 = reads 0. Control bits: [1:0] select, [2] enable, [3] auto-reload request. Select value k picks `tap_i[k]` as the count tick (bit 0 = 256 Hz, 1 = 32 Hz, 2 = 8 Hz, 3 = 2 Hz), and ticks on the other taps are ignored.
- R3: A high-nibble write leaves the count unchanged. A low-nibble write sets the count to {held high nibble, written low nibble} at the next clock edge.
- R4: With enable set and the count below FF, each selected tick raises the count by exactly one, beginning with the first tick after a load.
- R5: With enable at 0, the count holds its value and ignores all ticks.
- R6: `evt_o` is high for exactly the one cycle after the clock edge at which the count goes from FE to FF.
- R7: With reload active and the count at FF, a cycle with `tick8k_i` high loads the last loaded value back into the counter.
- R8: Writing the auto-reload request bit alone changes nothing in the counter. The request is sampled into the active reload state only at a low-nibble load.
- R9: A load of FF leaves the count at FF, deactivates reload, and clears the auto-reload request bit that the control register reads back.
- R10: Without active reload, the count remains at FF until the next load.
- R11: A read of the low nibble (`rd_i` with address 1) captures the current high half of the count. Reads of address 2 return that captured value until the next low read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data for `addr_i`, combinational |
| tap_i | input | 4 | Prescaler tick enables, one per rate |
| tick8k_i | input | 1 | 8 kHz tick enable used for reloads |
| evt_o | output | 1 | Timer event pulse |

## Verification
Every register update, count step, reload and snapshot capture takes effect at the clock edge where the strobe or tick is sampled. `rdata_o` decodes the current address combinationally, so a register read shows the new state in the cycle that follows that edge. `evt_o` is high in the same cycle in which the count first reads FF. The bench drives its inputs just after each rising edge and steps a behavioural model on that same edge. It compares the read data and the event flag with the model at every falling edge, and its directed checks sample at the falling edge that follows the causing edge.

// File: rtl/nt_pkg.sv
package nt_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_LO   = 2'd1,
    A_HI   = 2'd2,
    A_NONE = 2'd3
  } nt_addr_e;

  typedef struct packed {
    logic       auto_rl;
    logic       en;
    logic [1:0] sel;
  } nt_ctrl_t;
endpackage

// File: rtl/nt_tap_sel.sv
module nt_tap_sel #(
  parameter int N_TAPS = 4,
  localparam int SEL_W = $clog2(N_TAPS)
) (
  input  logic [N_TAPS-1:0] tap_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              tick_o
);
  logic [N_TAPS-1:0] hit;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign hit[g] = tap_i[g] & (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;

  always_comb begin
    if (!$isunknown(sel_i)) assert ($onehot0(hit)) else $error("p_onehot_tap_r2");
  end
endmodule

// File: rtl/nt_regs.sv
module nt_regs
  import nt_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int CNT_W = 2 * NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [NIB_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output nt_ctrl_t         ctrl_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [NIB_W-1:0] rdata_o
);
  nt_ctrl_t         ctrl_q;
  logic [NIB_W-1:0] hold_q, snap_q;
  logic             full_load;

  assign load_o     = wr_i && (addr_i == A_LO);
  assign load_val_o = {hold_q, wdata_i};
  assign full_load  = load_o && (load_val_o == '1);
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      hold_q <= '0;
      snap_q <= '0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= nt_ctrl_t'(wdata_i);
      else if (full_load)          ctrl_q.auto_rl <= 1'b0;
      if (wr_i && addr_i == A_HI)   hold_q <= wdata_i;
      if (rd_i && addr_i == A_LO)   snap_q <= cnt_i[CNT_W-1:NIB_W];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = NIB_W'(ctrl_q);
      A_LO:    rdata_o = cnt_i[NIB_W-1:0];
      A_HI:    rdata_o = snap_q;
      default: rdata_o = '0;
    endcase
  end

  p_ff_clears_auto_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_load |=> !ctrl_q.auto_rl);
  p_snap_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == A_LO) |=> $stable(snap_q));
endmodule

// File: rtl/nt_core.sv
module nt_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             auto_req_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             tick8k_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q, rl_q;
  logic             act_q, evt_q, reload, step;

  assign reload = (cnt_q == TOP) && act_q && tick8k_i;
  assign step   = en_i && tick_i && (cnt_q != TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rl_q  <= '0;
      act_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
        rl_q  <= load_val_i;
        act_q <= auto_req_i && (load_val_i != TOP);
      end else if (reload) begin
        cnt_q <= rl_q;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
        evt_q <= (cnt_q == TOP - 1'b1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i && !reload) |=> $stable(cnt_q));
  p_evt_at_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (cnt_q == TOP));
  p_evt_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);
  p_stuck_top_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == TOP && !act_q && !load_i) |=> (cnt_q == TOP));
  p_act_at_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
  p_unit_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !reload && cnt_q != TOP) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/nib_timer.sv
module nib_timer
  import nt_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int N_TAPS = 4,
  localparam int CNT_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [NIB_W-1:0]  rdata_o,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              tick8k_i,
  output logic              evt_o
);
  nt_ctrl_t         ctrl;
  logic             load, tick;
  logic [CNT_W-1:0] load_val, cnt;

  nt_regs #(.NIB_W(NIB_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .ctrl_o(ctrl), .load_o(load), .load_val_o(load_val), .rdata_o
  );

  nt_tap_sel #(.N_TAPS(N_TAPS)) u_tap_sel (
    .tap_i, .sel_i(ctrl.sel), .tick_o(tick)
  );

  nt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .auto_req_i(ctrl.auto_rl), .en_i(ctrl.en), .tick_i(tick),
    .tick8k_i, .cnt_o(cnt), .evt_o
  );
endmodule

// File: tb/nib_timer_bench.sv
module nib_timer_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [3:0] wdata = 4'd0, rdata;
  logic [3:0] tap, man_tap = 4'd0, gen_tap;
  logic       t8k, man_t8 = 1'b0, gen_t8;
  logic       gen_en = 1'b0, evt;
  int         n_chk = 0, n_fail = 0, gcnt = 0;

  always #4 clk = ~clk;

  nib_timer u_nib_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tap_i(tap), .tick8k_i(t8k), .evt_o(evt)
  );

  assign gen_tap = {gcnt % 11 == 0, gcnt % 7 == 0, gcnt % 5 == 0, gcnt % 2 == 0};
  assign gen_t8  = (gcnt % 3 == 0);
  assign tap = gen_en ? gen_tap : man_tap;
  assign t8k = gen_en ? gen_t8 : man_t8;

  always @(posedge clk) begin #1; gcnt <= gcnt + 1; end

  // behavioural reference
  int m_sel = 0, m_en = 0, m_auto = 0, m_hold = 0, m_load = 0;
  int m_cnt = 0, m_act = 0, m_snap = 0, m_evt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_en = 0; m_auto = 0; m_hold = 0; m_load = 0;
      m_cnt = 0; m_act = 0; m_snap = 0; m_evt = 0;
    end else begin
      int old_cnt;
      old_cnt = m_cnt;
      m_evt = 0;
      if (wr && addr == 2'd1) begin
        m_cnt = m_hold * 16 + wdata;
        m_load = m_cnt;
        if (m_cnt == 255) begin m_act = 0; m_auto = 0; end
        else m_act = m_auto;
      end else if (m_cnt == 255 && m_act == 1 && t8k) begin
        m_cnt = m_load;
      end else if (m_en == 1 && tap[m_sel] && m_cnt != 255) begin
        if (m_cnt == 254) m_evt = 1;
        m_cnt = m_cnt + 1;
      end
      if (wr && addr == 2'd0) begin
        m_sel = wdata[1:0]; m_en = wdata[2]; m_auto = wdata[3];
      end
      if (wr && addr == 2'd2) m_hold = wdata;
      if (rd && addr == 2'd1) m_snap = old_cnt / 16;
    end
  end

  task automatic cmp(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int e;
      case (addr)
        2'd0: e = m_auto * 8 + m_en * 4 + m_sel;
        2'd1: e = m_cnt % 16;
        2'd2: e = m_snap;
        default: e = 0;
      endcase
      cmp("R6 evt model", int'(evt), m_evt);
      cmp((addr == 2'd0) ? "R2 ctrl model" : (addr == 2'd2) ? "R11 snap model" : "R4 count model",
          int'(rdata), e);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [3:0] d);
    wr = 1'b1; addr = a; wdata = d;
    cyc();
    wr = 1'b0; addr = 2'd1;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [3:0] v);
    rd = 1'b1; addr = a;
    @(negedge clk); v = rdata;
    cyc();
    rd = 1'b0; addr = 2'd1;
  endtask

  task automatic pulse(input logic [3:0] tv, input logic t8);
    man_tap = tv; man_t8 = t8;
    cyc();
    man_tap = 4'd0; man_t8 = 1'b0;
  endtask

  task automatic rd_count(output int v);
    logic [3:0] lo, hi;
    do_rd(2'd1, lo);
    do_rd(2'd2, hi);
    v = hi * 16 + lo;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] v;
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R1
    do_rd(2'd0, v); cmp("R1 ctrl after reset", v, 0);
    rd_count(c);    cmp("R1 count after reset", c, 0);
    cmp("R1 evt after reset", evt, 0);
    // R3 / R11
    do_wr(2'd2, 4'h3);
    rd_count(c);    cmp("R3 high write no load", c, 0);
    do_wr(2'd1, 4'h5);
    rd_count(c);    cmp("R3 R11 low write loads", c, 8'h35);
    // R5
    gen_en = 1'b1;
    repeat (20) cyc();
    gen_en = 1'b0;
    rd_count(c);    cmp("R5 disabled holds", c, 8'h35);
    // R2 / R4 select 2
    do_wr(2'd0, 4'b0110);
    pulse(4'b1011, 1'b1);
    rd_count(c);    cmp("R2 other taps ignored", c, 8'h35);
    pulse(4'b0100, 1'b0);
    rd_count(c);    cmp("R4 one step", c, 8'h36);
    // R2 select 3
    do_wr(2'd0, 4'b0111);
    pulse(4'b0111, 1'b0);
    rd_count(c);    cmp("R2 sel3 ignores low taps", c, 8'h36);
    pulse(4'b1000, 1'b0);
    rd_count(c);    cmp("R2 sel3 tap counts", c, 8'h37);
    // R6 / R10 no auto
    do_wr(2'd0, 4'b0110);
    do_wr(2'd2, 4'hF);
    do_wr(2'd1, 4'hD);
    pulse(4'b0100, 1'b0);
    cmp("R6 no evt at FE", evt, 0);
    pulse(4'b0100, 1'b0);
    cmp("R6 evt at FF", evt, 1);
    cyc();
    cmp("R6 evt one cycle", evt, 0);
    pulse(4'b0100, 1'b1);
    pulse(4'b0100, 1'b1);
    rd_count(c);    cmp("R10 stays at FF", c, 8'hFF);
    // R8 request alone
    do_wr(2'd0, 4'b1110);
    pulse(4'b0100, 1'b1);
    pulse(4'b0000, 1'b1);
    rd_count(c);    cmp("R8 auto bit alone no restart", c, 8'hFF);
    // R7 reload after load with auto
    do_wr(2'd1, 4'hC);
    pulse(4'b0100, 1'b0);
    pulse(4'b0100, 1'b0);
    pulse(4'b0100, 1'b0);
    cmp("R7 evt before reload", evt, 1);
    pulse(4'b0000, 1'b1);
    rd_count(c);    cmp("R7 reload value", c, 8'hFC);
    // R9 load FF
    do_wr(2'd1, 4'hF);
    do_rd(2'd0, v); cmp("R9 auto bit cleared", v, 4'b0110);
    pulse(4'b0100, 1'b1);
    pulse(4'b0100, 1'b1);
    rd_count(c);    cmp("R9 stopped at FF", c, 8'hFF);
    do_rd(2'd3, v); cmp("R2 unused address", v, 0);
    // mixed traffic against the model
    gen_en = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      if (r < 2)       do_wr(2'd0, 4'(($urandom % 16) | 4));
      else if (r < 3)  do_wr(2'd2, ($urandom % 4 == 0) ? 4'(($urandom % 16)) : 4'hF);
      else if (r < 4)  do_wr(2'd1, 4'($urandom % 16));
      else if (r < 7)  do_rd(2'($urandom % 4), v);
      else             cyc();
    end
    gen_en = 1'b0;
    cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule